// File: doc/BRIEF.md
# Six-Line ALU with Output Shifter and Status Flags

This block is the arithmetic and logic stage of a microcoded data path. A left operand from a holding register and a right operand from the B bus enter combinationally. Six control lines pick the result: a two-bit function code, two operand enables, an invert for the left operand and a carry-in increment. A single adder and a small logic unit therefore produce copy, add, increment, negate, subtract, AND, OR and NOT results.

The result then passes through an output shifter driven by two lines, and the shifted value goes onto the C bus. Negative and zero status bits come from the unshifted result. They are captured in flip-flops on every rising clock edge so that the sequencer can branch on them in a later microinstruction.

Top module: `alu_shift_top`

## Requirements
- R1: A disabled operand (`en_a` or `en_b` low) enters the function unit as all zeros.
- R2: When `inv_a` is high, the left operand is bitwise complemented after gating. With `en_a` low and `inv_a` high, the left operand is all ones.
- R3: `fn_sel` = {F0,F1} selects the function: 2'b00 gives AND, 2'b01 gives OR, 2'b10 gives NOT of the right operand, and 2'b11 gives ADD.
- R4: `inc` is the carry into the adder, so with `fn_sel`=2'b11 the sum gains one. Under the three logic functions `inc` has no effect on the result.
- R5: The addition wraps modulo 2^W, and no carry-out is kept.
- R6: With `sh_sll8` and `sh_sra1` both low, `c_out` equals the ALU result unchanged.
- R7: With `sh_sll8` high, `c_out` is the ALU result shifted left by 8 bits, with zeros filling in from the right.
- R8: With only `sh_sra1` high, `c_out` is the ALU result shifted right by one bit, and the sign bit is copied into the top bit.
- R9: When both shift lines are high, the left shift by 8 is the one applied.
- R10: At each rising edge `neg_q` loads the MSB of the unshifted ALU result.
- R11: At each rising edge `zero_q` loads 1 exactly when the unshifted ALU result is all zeros. A shift does not change it.
- R12: A low `rst_n` clears both flags at once, without waiting for a clock edge. After `rst_n` rises, the flags hold zero through two rising edges and load normally from the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag flip-flops |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | Left operand, from the holding register |
| b_in | input | W | Right operand, from the B bus |
| fn_sel | input | 2 | Function code {F0,F1} |
| en_a | input | 1 | Left operand enable |
| en_b | input | 1 | Right operand enable |
| inv_a | input | 1 | Complement the left operand |
| inc | input | 1 | Carry into the adder |
| sh_sll8 | input | 1 | Logical left shift by 8 |
| sh_sra1 | input | 1 | Arithmetic right shift by 1 |
| c_out | output | W | Shifted result onto the C bus |
| neg_q | output | 1 | Registered negative flag |
| zero_q | output | 1 | Registered zero flag |

## Verification
The hardest case to reach from the ports is one where the flags and the bus disagree. This happens when a shift pushes all the nonzero bits out of a nonzero ALU result, or moves a bit into or out of the sign position. In that case `c_out` is zero while `zero_q` must stay 0. The stimulus builds this on purpose. It passes 0x0100_0000 through with the left shift, so the bus reads zero but the captured zero flag does not. It also applies both shift lines to a negative value, which checks shift priority and the pre-shift negative flag together. A further directed sequence pulls reset low partway through a cycle, while the zero flag is set. It then counts the edges after release to confirm the two-stage release.

// File: rtl/alu_pkg.sv
package alu_pkg;
  // Function code, written {F0,F1}
  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_ADD  = 2'b11
  } alu_fn_e;

  typedef enum logic [1:0] {
    SH_NONE,
    SH_LEFT,
    SH_RIGHT
  } shift_mode_e;
endpackage

// File: rtl/alu_operand_stage.sv
module alu_operand_stage #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_raw,
  input  logic [W-1:0] b_raw,
  input  logic         en_a,
  input  logic         en_b,
  input  logic         inv_a,
  output logic [W-1:0] a_op,
  output logic [W-1:0] b_op
);
  logic [W-1:0] a_gated;

  always_comb begin
    a_gated = en_a ? a_raw : '0;
    a_op    = inv_a ? ~a_gated : a_gated;
    b_op    = en_b ? b_raw : '0;
  end
endmodule

// File: rtl/alu_function_unit.sv
module alu_function_unit
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_op,
  input  logic [W-1:0] b_op,
  input  alu_fn_e      fn,
  input  logic         carry_in,
  output logic [W-1:0] res
);
  logic [W-1:0] sum;

  always_comb begin
    sum = a_op + b_op + {{(W-1){1'b0}}, carry_in};
    unique case (fn)
      FN_AND:  res = a_op & b_op;
      FN_OR:   res = a_op | b_op;
      FN_NOTB: res = ~b_op;
      default: res = sum;
    endcase
  end
endmodule

// File: rtl/alu_out_shifter.sv
module alu_out_shifter
  import alu_pkg::*;
#(
  parameter int W       = 32,
  parameter int SHL_AMT = 8
) (
  input  logic [W-1:0] din,
  input  logic         sll_req,
  input  logic         sra_req,
  output logic [W-1:0] dout
);
  shift_mode_e mode;

  always_comb begin
    if (sll_req)      mode = SH_LEFT;   // left shift wins when both are set
    else if (sra_req) mode = SH_RIGHT;
    else              mode = SH_NONE;
  end

  always_comb begin
    unique case (mode)
      SH_LEFT:  dout = {din[W-1-SHL_AMT:0], {SHL_AMT{1'b0}}};
      SH_RIGHT: dout = {din[W-1], din[W-1:1]};
      default:  dout = din;
    endcase
  end
endmodule

// File: rtl/alu_status_flags.sv
module alu_status_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n_i,
  input  logic [W-1:0] alu_res,
  output logic         neg_q,
  output logic         zero_q
);
  logic neg_d, zero_d;
  logic load_en;
  logic past_ok;

  assign load_en = 1'b1;  // flags capture on every cycle

  always_comb begin
    neg_d  = alu_res[W-1];
    zero_d = (alu_res == '0);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      neg_q   <= 1'b0;
      zero_q  <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (load_en) begin
        neg_q  <= neg_d;
        zero_q <= zero_d;
      end
    end
  end

  // R10
  a_r10_neg_capture: assert property (@(posedge clk) disable iff (!rst_n_i)
    past_ok |-> (neg_q == $past(alu_res[W-1])));
  // R11
  a_r11_zero_capture: assert property (@(posedge clk) disable iff (!rst_n_i)
    past_ok |-> (zero_q == ($past(alu_res) == '0)));
  // R11: both flags cannot be set together
  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(neg_q && zero_q));
endmodule

// File: rtl/alu_shift_top.sv
module alu_shift_top
  import alu_pkg::*;
#(
  parameter int W       = 32,
  parameter int SHL_AMT = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [1:0]   fn_sel,
  input  logic         en_a,
  input  logic         en_b,
  input  logic         inv_a,
  input  logic         inc,
  input  logic         sh_sll8,
  input  logic         sh_sra1,
  output logic [W-1:0] c_out,
  output logic         neg_q,
  output logic         zero_q
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic [W-1:0]           a_op, b_op, alu_res;
  alu_fn_e                fn;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  assign fn = alu_fn_e'(fn_sel);

  alu_operand_stage #(.W(W)) u_ops (
    .a_raw (a_in),
    .b_raw (b_in),
    .en_a  (en_a),
    .en_b  (en_b),
    .inv_a (inv_a),
    .a_op  (a_op),
    .b_op  (b_op)
  );

  alu_function_unit #(.W(W)) u_fu (
    .a_op     (a_op),
    .b_op     (b_op),
    .fn       (fn),
    .carry_in (inc),
    .res      (alu_res)
  );

  alu_out_shifter #(.W(W), .SHL_AMT(SHL_AMT)) u_sh (
    .din     (alu_res),
    .sll_req (sh_sll8),
    .sra_req (sh_sra1),
    .dout    (c_out)
  );

  alu_status_flags #(.W(W)) u_flags (
    .clk     (clk),
    .rst_n_i (rst_sync_n),
    .alu_res (alu_res),
    .neg_q   (neg_q),
    .zero_q  (zero_q)
  );

  // R1
  a_r1_gated_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!en_a && !en_b && !inv_a && fn_sel == 2'b01) |-> (alu_res == '0));
  // R6
  a_r6_passthrough: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sh_sll8 && !sh_sra1) |-> (c_out == alu_res));
  // R7
  a_r7_left_fill: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sh_sll8 |-> (c_out[SHL_AMT-1:0] == '0));
  // R8
  a_r8_sign_keep: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sh_sra1 && !sh_sll8) |-> (c_out[W-1] == alu_res[W-1]));
  // R12
  a_r12_reset_clear: assert property (@(posedge clk)
    !rst_sync_n |-> (!neg_q && !zero_q));
endmodule

// File: tb/sim_alu_shift_top.sv
module sim_alu_shift_top;
  typedef struct packed {
    logic [7:0]  req;
    logic [1:0]  fn;
    logic        ea;
    logic        eb;
    logic        ia;
    logic        ic;
    logic        sl;
    logic        sr;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] c;
    logic        n;
    logic        z;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [0:NV-1] = '{
    '{8'd3,  2'b01,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h1234_5678,32'h0,        32'h1234_5678,1'b0,1'b0}, // R3 copy A
    '{8'd3,  2'b11,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h5,        32'h7,        32'hC,        1'b0,1'b0}, // R3 add
    '{8'd4,  2'b11,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,32'hFFFF_FFFF,32'h0,        32'h0,        1'b0,1'b1}, // R4 increment wraps
    '{8'd2,  2'b11,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h1,        32'h0,        32'hFFFF_FFFF,1'b1,1'b0}, // R2 negate
    '{8'd3,  2'b00,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'hF0F0_F0F0,32'hFF00_FF00,32'hF000_F000,1'b1,1'b0}, // R3 AND
    '{8'd3,  2'b01,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0F00_0000,32'h0000_00F0,32'h0F00_00F0,1'b0,1'b0}, // R3 OR
    '{8'd3,  2'b10,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h1234,     32'h0,        32'hFFFF_FFFF,1'b1,1'b0}, // R3 NOT B
    '{8'd2,  2'b11,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,32'h3,        32'hA,        32'h7,        1'b0,1'b0}, // R2 B minus A
    '{8'd11, 2'b01,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,32'h0100_0000,32'h0,        32'h0,        1'b0,1'b0}, // R11 R7 bus zero, flag not
    '{8'd8,  2'b01,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,32'h8000_0004,32'h0,        32'hC000_0002,1'b1,1'b0}, // R8 sign fill
    '{8'd4,  2'b00,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,32'h6,        32'h3,        32'h2,        1'b0,1'b0}, // R4 inc ignored
    '{8'd9,  2'b01,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,32'h8000_0001,32'h0,        32'h0000_0100,1'b1,1'b0}, // R9 R10 left wins
    '{8'd2,  2'b11,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'hABCD,     32'h5555,     32'hFFFF_FFFF,1'b1,1'b0}, // R2 minus one
    '{8'd1,  2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'hDEAD,     32'hBEEF,     32'h0,        1'b0,1'b1}, // R1 both gated
    '{8'd5,  2'b11,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h7FFF_FFFF,32'h1,        32'h8000_0000,1'b1,1'b0}  // R5 wrap
  };

  logic        clk, rst_n;
  logic [31:0] a_in, b_in, c_out;
  logic [1:0]  fn_sel;
  logic        en_a, en_b, inv_a, inc, sh_sll8, sh_sra1, neg_q, zero_q;
  int          n_chk, n_bad;
  logic        done;

  alu_shift_top u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .fn_sel(fn_sel),
    .en_a(en_a), .en_b(en_b), .inv_a(inv_a), .inc(inc),
    .sh_sll8(sh_sll8), .sh_sra1(sh_sra1),
    .c_out(c_out), .neg_q(neg_q), .zero_q(zero_q)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    fn_sel = v.fn; en_a = v.ea; en_b = v.eb; inv_a = v.ia; inc = v.ic;
    sh_sll8 = v.sl; sh_sra1 = v.sr; a_in = v.a; b_in = v.b;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    apply(TBL[13]);  // zero result: flags would set if not in reset
    repeat (3) @(posedge clk);
    #1;
    check("R12 reset neg", {31'b0, neg_q}, 32'h0);
    check("R12 reset zero", {31'b0, zero_q}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(TBL[i]);
      #1;
      check($sformatf("R%0d vec%0d c_out", TBL[i].req, i), c_out, TBL[i].c);
      @(posedge clk); #1;
      check($sformatf("R10 vec%0d neg", i), {31'b0, neg_q}, {31'b0, TBL[i].n});
      check($sformatf("R11 vec%0d zero", i), {31'b0, zero_q}, {31'b0, TBL[i].z});
    end

    // R12: asynchronous clear, then two-edge release
    @(negedge clk);
    apply(TBL[13]);
    @(posedge clk); #1;
    check("R11 zero set before reset", {31'b0, zero_q}, 32'h1);
    #1 rst_n = 1'b0;
    #0.5;
    check("R12 async clear", {31'b0, zero_q}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R12 held edge1", {31'b0, zero_q}, 32'h0);
    @(posedge clk); #1;
    check("R12 held edge2", {31'b0, zero_q}, 32'h0);
    @(posedge clk); #1;
    check("R12 loads edge3", {31'b0, zero_q}, 32'h1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule